// File: doc/BRIEF.md
# Thread-Block Admission and Warp Allocator

This block sits between an upstream work distributor and one multiprocessor model. The distributor presents a block request: a thread count, a register count per thread and a number of shared-memory units. The allocator accepts a request only if every resource pool can hold the whole block at once. The pools are warp slots, registers, shared memory and block slots, and each block slot carries one barrier. When a request is accepted, the block-level resources and the warp and register budget are all reserved in the same cycle. The warps are then issued one per cycle, each with a warp-id and a sub-partition.

A warp gives back its slot and its registers when two events have happened in order: its threads have finished, and its in-flight instructions have drained. Once the last warp of a block is released, the block waits in a completion set. The allocator reports the lowest pending block-id to the distributor and holds it until the distributor acknowledges it. The acknowledgement returns the block's shared memory and block slot. Several blocks may be resident together. Their number is bounded by the 64 warp slots, which is 2048 threads, and by the 16 block slots.

Top module: `block_dispatch`

## Requirements
- R1: A block of T threads (1 to 2047) needs ceil(T/32) warps, and exactly that many warp issues follow its admission.
- R2: `req_ready` is high only when no warp issue is in progress and every pool is large enough: free warp slots at least the warp count, free registers at least warps*32*`req_regs` (pool of 65536), free shared memory at least `req_smem` (pool of 64 units) and at least one of 16 block slots free. Admission happens on a clock edge with `req_valid` and `req_ready` both high.
- R3: Starting in the cycle after admission, `warp_valid` is high for one cycle per warp. `warp_id` is the lowest free warp slot, `warp_blk` is the block-id (the lowest free block slot at admission), and a warp-id is never handed out while it is still held.
- R4: `warp_sub` cycles 0,1,2,3,0,... over successive warps. The pointer carries over from one block to the next.
- R5: A warp is released only by a `drain_valid` for its id that arrives after a `fin_valid` for its id. A drain with no earlier finish is ignored, and so is a finish or drain aimed at a free slot.
- R6: The registers of a warp return to the pool as soon as that warp is released, before the block completes.
- R7: When the last warp of a block is released, `done_valid` rises in the next cycle with `done_id` set to the block-id. It stays high until `done_ack`. When several blocks are pending, the lowest block-id is shown first.
- R8: A block's shared memory and block slot are freed only when its completion is acknowledged.
- R9: After reset all pools are full, `warp_valid` and `done_valid` are low, and the sub-partition pointer is 0.
- R10: Eight resident blocks of 256 threads fill all 64 warp slots. A further block of 32 threads is then refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Block request present |
| req_threads | input | 11 | Threads in the block |
| req_regs | input | 8 | Registers per thread |
| req_smem | input | 7 | Shared-memory units for the block |
| req_ready | output | 1 | Request can be admitted this cycle |
| warp_valid | output | 1 | A warp is issued this cycle |
| warp_id | output | 6 | Warp slot of the issued warp |
| warp_sub | output | 2 | Sub-partition of the issued warp |
| warp_blk | output | 4 | Block-id of the issued warp |
| fin_valid | input | 1 | All threads of warp `fin_id` have finished |
| fin_id | input | 6 | Warp slot that finished |
| drain_valid | input | 1 | In-flight instructions of warp `drain_id` have drained |
| drain_id | input | 6 | Warp slot that drained |
| done_valid | output | 1 | A block has completed |
| done_id | output | 4 | Block-id of the reported completion |
| done_ack | input | 1 | Distributor accepts the reported completion |

## Verification
The checker watches four properties on every cycle. Admission is closed while warps are being issued. An admission is always followed by a warp in the next cycle. A warp-id is never issued twice while it is held. The sub-partition steps by one from each issued warp to the next. It also checks that a reported completion stays up until it is acknowledged. The exact admission limits of each pool, the release order of finish and drain, the early return of registers, the late return of shared memory and the ordering of simultaneous completions depend on sequences of requests. Only the bench scenarios can show those.

// File: rtl/dispatch_pkg.sv
// Package: shared defaults for the block allocator.
// Assumes: warp size is a power of two and divides evenly into lanes.
package dispatch_pkg;
    localparam int DEF_SLOTS      = 64;
    localparam int DEF_SUBS       = 4;
    localparam int DEF_WARP_SIZE  = 32;
    localparam int DEF_BLOCKS     = 16;
    localparam int DEF_REG_TOTAL  = 65536;
    localparam int DEF_SMEM_TOTAL = 64;

    // Round-up division used for warp counts.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/warp_pool.sv
// warp_pool: holds one state entry per warp slot (held, finished, owner block).
// Gives the lowest free slot for the next issue and flags a release when a
// drain arrives for a held slot that has already finished.
// Assumes: at most one issue per cycle, and the issued slot is free.
module warp_pool #(
    parameter int NUM_SLOTS = 64,
    parameter int BLK_W     = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BLK_W-1:0]  launch_blk,
    input  logic              fin_valid,
    input  logic [SLOT_W-1:0] fin_id,
    input  logic              drain_valid,
    input  logic [SLOT_W-1:0] drain_id,
    output logic [SLOT_W-1:0] pick_id,
    output logic              rel_valid,
    output logic [BLK_W-1:0]  rel_blk
);
    logic [NUM_SLOTS-1:0] held;
    logic [NUM_SLOTS-1:0] finished;
    logic [BLK_W-1:0]     owner [NUM_SLOTS];

    // Release needs the finish mark to be set already.
    assign rel_valid = drain_valid && held[drain_id] && finished[drain_id];
    assign rel_blk   = owner[drain_id];

    // Lowest free slot, a fixed-priority search.
    always_comb begin
        pick_id = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!held[i]) pick_id = SLOT_W'(i);
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic             held_q;
        logic             fin_q;
        logic [BLK_W-1:0] own_q;

        // Per-slot state: claim on issue, mark on finish, clear on release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= 1'b0;
                fin_q  <= 1'b0;
                own_q  <= '0;
            end else if (launch && pick_id == SLOT_W'(g)) begin
                held_q <= 1'b1;
                fin_q  <= 1'b0;
                own_q  <= launch_blk;
            end else if (rel_valid && drain_id == SLOT_W'(g)) begin
                held_q <= 1'b0;
                fin_q  <= 1'b0;
            end else if (fin_valid && fin_id == SLOT_W'(g) && held_q) begin
                fin_q  <= 1'b1;
            end
        end

        assign held[g]     = held_q;
        assign finished[g] = fin_q;
        assign owner[g]    = own_q;
    end
endmodule

// File: rtl/block_table.sv
// block_table: one entry per resident block, holding warps still live, the
// shared-memory units held and the registers per warp. It records completion
// when the last warp is released and reports the lowest pending id until acked.
// Assumes: a block's warp count at allocation is at least one.
module block_table #(
    parameter int MAX_BLOCKS = 16,
    parameter int WCNT_W     = 7,
    parameter int SMEM_W     = 7,
    parameter int RPW_W      = 17,
    localparam int BLK_W     = $clog2(MAX_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [WCNT_W-1:0] alloc_warps,
    input  logic [SMEM_W-1:0] alloc_smem,
    input  logic [RPW_W-1:0]  alloc_rpw,
    input  logic              rel_valid,
    input  logic [BLK_W-1:0]  rel_blk,
    input  logic              ack,
    output logic [BLK_W-1:0]  free_id,
    output logic              any_free,
    output logic              done_valid,
    output logic [BLK_W-1:0]  done_id,
    output logic [SMEM_W-1:0] done_smem,
    output logic [RPW_W-1:0]  rel_rpw
);
    logic [MAX_BLOCKS-1:0] used;
    logic [MAX_BLOCKS-1:0] pend;
    logic [SMEM_W-1:0]     smem [MAX_BLOCKS];
    logic [RPW_W-1:0]      rpw  [MAX_BLOCKS];

    assign any_free   = ~&used;
    assign done_valid = |pend;
    assign done_smem  = smem[done_id];
    assign rel_rpw    = rpw[rel_blk];

    // Lowest free entry and lowest pending completion.
    always_comb begin
        free_id = '0;
        done_id = '0;
        for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
            if (!used[i]) free_id = BLK_W'(i);
            if (pend[i])  done_id = BLK_W'(i);
        end
    end

    for (genvar g = 0; g < MAX_BLOCKS; g++) begin : g_blk
        logic              used_q;
        logic              pend_q;
        logic [WCNT_W-1:0] live_q;
        logic [SMEM_W-1:0] smem_q;
        logic [RPW_W-1:0]  rpw_q;

        // Entry life: fill on alloc, count down releases, free on ack.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_q <= 1'b0;
                pend_q <= 1'b0;
                live_q <= '0;
                smem_q <= '0;
                rpw_q  <= '0;
            end else if (alloc && free_id == BLK_W'(g)) begin
                used_q <= 1'b1;
                pend_q <= 1'b0;
                live_q <= alloc_warps;
                smem_q <= alloc_smem;
                rpw_q  <= alloc_rpw;
            end else if (rel_valid && rel_blk == BLK_W'(g)) begin
                live_q <= live_q - WCNT_W'(1);
                if (live_q == WCNT_W'(1)) pend_q <= 1'b1;
            end else if (ack && done_valid && done_id == BLK_W'(g)) begin
                used_q <= 1'b0;
                pend_q <= 1'b0;
            end
        end

        assign used[g] = used_q;
        assign pend[g] = pend_q;
        assign smem[g] = smem_q;
        assign rpw[g]  = rpw_q;
    end
endmodule

// File: rtl/block_dispatch.sv
// block_dispatch: admits a block request only if warp slots, registers,
// shared memory and a block slot all suffice, reserves them in one cycle, then
// issues one warp per cycle with round-robin sub-partitions. Registers come
// back per warp and shared memory per acknowledged block completion.
// Assumes: the request fields stay stable while req_valid is high.
module block_dispatch
    import dispatch_pkg::*;
#(
    parameter int NUM_SLOTS  = DEF_SLOTS,
    parameter int NUM_SUB    = DEF_SUBS,
    parameter int WARP_SIZE  = DEF_WARP_SIZE,
    parameter int MAX_BLOCKS = DEF_BLOCKS,
    parameter int REG_TOTAL  = DEF_REG_TOTAL,
    parameter int SMEM_TOTAL = DEF_SMEM_TOTAL,
    parameter int THR_W      = 11,
    parameter int RPT_W      = 8,
    parameter int SMEM_W     = 7,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int SUB_W     = $clog2(NUM_SUB),
    localparam int BLK_W     = $clog2(MAX_BLOCKS),
    localparam int WCNT_W    = $clog2(NUM_SLOTS + 1),
    localparam int REG_W     = $clog2(REG_TOTAL + 1),
    localparam int SMEM_CW   = $clog2(SMEM_TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [THR_W-1:0]  req_threads,
    input  logic [RPT_W-1:0]  req_regs,
    input  logic [SMEM_W-1:0] req_smem,
    output logic              req_ready,
    output logic              warp_valid,
    output logic [SLOT_W-1:0] warp_id,
    output logic [SUB_W-1:0]  warp_sub,
    output logic [BLK_W-1:0]  warp_blk,
    input  logic              fin_valid,
    input  logic [SLOT_W-1:0] fin_id,
    input  logic              drain_valid,
    input  logic [SLOT_W-1:0] drain_id,
    output logic              done_valid,
    output logic [BLK_W-1:0]  done_id,
    input  logic              done_ack
);
    logic [WCNT_W-1:0]  free_warps;
    logic [REG_W-1:0]   free_regs;
    logic [SMEM_CW-1:0] free_smem;
    logic [WCNT_W-1:0]  left_q;
    logic [BLK_W-1:0]   cur_blk;
    logic [SUB_W-1:0]   rr_q;
    logic [31:0]        need_w;
    logic [31:0]        need_regs;
    logic [REG_W-1:0]   need_rpw;
    logic               admit;
    logic               rel_valid;
    logic [BLK_W-1:0]   rel_blk;
    logic [REG_W-1:0]   rel_rpw;
    logic [BLK_W-1:0]   free_blk;
    logic               any_free;
    logic [SMEM_W-1:0]  done_smem;
    logic               ret_blk;

    // Demand of the presented request in warps and registers.
    always_comb begin
        need_w    = 32'(ceil_div(int'(req_threads), WARP_SIZE));
        need_rpw  = REG_W'(32'(req_regs) * 32'(WARP_SIZE));
        need_regs = need_w * 32'(need_rpw);
    end

    // All-or-nothing admission test over every pool.
    assign req_ready = (left_q == '0) && (need_w != 32'd0)
                    && (need_w <= 32'(free_warps))
                    && (need_regs <= 32'(free_regs))
                    && (32'(req_smem) <= 32'(free_smem))
                    && any_free;
    assign admit     = req_valid && req_ready;
    assign ret_blk   = done_ack && done_valid;

    assign warp_valid = (left_q != '0);
    assign warp_sub   = rr_q;
    assign warp_blk   = cur_blk;

    // Pool counters: reserve at admission, return per warp and per block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_warps <= WCNT_W'(NUM_SLOTS);
            free_regs  <= REG_W'(REG_TOTAL);
            free_smem  <= SMEM_CW'(SMEM_TOTAL);
        end else begin
            free_warps <= free_warps - (admit ? WCNT_W'(need_w) : '0)
                                     + (rel_valid ? WCNT_W'(1) : '0);
            free_regs  <= free_regs - (admit ? REG_W'(need_regs) : '0)
                                    + (rel_valid ? rel_rpw : '0);
            free_smem  <= free_smem - (admit ? SMEM_CW'(req_smem) : '0)
                                    + (ret_blk ? SMEM_CW'(done_smem) : '0);
        end
    end

    // Issue sequencer: load the warp count, count down one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            cur_blk <= '0;
        end else if (admit) begin
            left_q  <= WCNT_W'(need_w);
            cur_blk <= free_blk;
        end else if (warp_valid) begin
            left_q  <= left_q - WCNT_W'(1);
        end
    end

    // Sub-partition pointer, kept across blocks.
    always_ff @(posedge clk) begin
        if (!rst_n)          rr_q <= '0;
        else if (warp_valid) rr_q <= (rr_q == SUB_W'(NUM_SUB - 1)) ? '0 : rr_q + SUB_W'(1);
    end

    warp_pool #(
        .NUM_SLOTS (NUM_SLOTS),
        .BLK_W     (BLK_W)
    ) i_pool (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (warp_valid),
        .launch_blk  (cur_blk),
        .fin_valid   (fin_valid),
        .fin_id      (fin_id),
        .drain_valid (drain_valid),
        .drain_id    (drain_id),
        .pick_id     (warp_id),
        .rel_valid   (rel_valid),
        .rel_blk     (rel_blk)
    );

    block_table #(
        .MAX_BLOCKS (MAX_BLOCKS),
        .WCNT_W     (WCNT_W),
        .SMEM_W     (SMEM_W),
        .RPW_W      (REG_W)
    ) i_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc       (admit),
        .alloc_warps (WCNT_W'(need_w)),
        .alloc_smem  (req_smem),
        .alloc_rpw   (need_rpw),
        .rel_valid   (rel_valid),
        .rel_blk     (rel_blk),
        .ack         (done_ack),
        .free_id     (free_blk),
        .any_free    (any_free),
        .done_valid  (done_valid),
        .done_id     (done_id),
        .done_smem   (done_smem),
        .rel_rpw     (rel_rpw)
    );
endmodule

// File: rtl/block_dispatch_chk.sv
// block_dispatch_chk: cycle-by-cycle properties of the allocator's ports.
// Assumes: default parameters of block_dispatch.
module block_dispatch_chk #(
    parameter int NUM_SLOTS = 64,
    parameter int NUM_SUB   = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int SUB_W    = $clog2(NUM_SUB)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              warp_valid,
    input logic [SLOT_W-1:0] warp_id,
    input logic [SUB_W-1:0]  warp_sub,
    input logic              fin_valid,
    input logic [SLOT_W-1:0] fin_id,
    input logic              drain_valid,
    input logic [SLOT_W-1:0] drain_id,
    input logic              done_valid,
    input logic              done_ack
);
    logic [NUM_SLOTS-1:0] seen_held;
    logic [NUM_SLOTS-1:0] seen_fin;
    logic                 have_last;
    logic [SUB_W-1:0]     last_sub;

    // Track held warp-ids from the issue and finish/drain ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_held <= '0;
            seen_fin  <= '0;
        end else begin
            if (fin_valid && seen_held[fin_id]) seen_fin[fin_id] <= 1'b1;
            if (drain_valid && seen_held[drain_id] && seen_fin[drain_id]) begin
                seen_held[drain_id] <= 1'b0;
                seen_fin[drain_id]  <= 1'b0;
            end
            if (warp_valid) begin
                seen_held[warp_id] <= 1'b1;
                seen_fin[warp_id]  <= 1'b0;
            end
        end
    end

    // Remember the previous issued sub-partition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;
            last_sub  <= '0;
        end else if (warp_valid) begin
            have_last <= 1'b1;
            last_sub  <= warp_sub;
        end
    end

    // R2: admission is closed while warps are issued
    p_closed_in_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> !req_ready);

    // R3: every admission is followed by a warp issue
    p_issue_after_admit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> warp_valid);

    // R3: a held warp-id is never issued again
    p_unique_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> !seen_held[warp_id]);

    // R4: sub-partition advances by one per issued warp
    p_round_robin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_valid && have_last) |->
            warp_sub == ((last_sub == SUB_W'(NUM_SUB - 1)) ? '0 : last_sub + SUB_W'(1)));

    // R9: the first warp after reset goes to sub-partition 0
    p_first_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_valid && !have_last) |-> warp_sub == '0);

    // R7: a reported completion holds until acknowledged
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ack) |=> done_valid);
endmodule

bind block_dispatch block_dispatch_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .warp_valid  (warp_valid),
    .warp_id     (warp_id),
    .warp_sub    (warp_sub),
    .fin_valid   (fin_valid),
    .fin_id      (fin_id),
    .drain_valid (drain_valid),
    .drain_id    (drain_id),
    .done_valid  (done_valid),
    .done_ack    (done_ack)
);

// File: tb/test_block_dispatch.sv
module test_block_dispatch;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [10:0] req_threads;
    logic [7:0]  req_regs;
    logic [6:0]  req_smem;
    logic        req_ready;
    logic        warp_valid;
    logic [5:0]  warp_id;
    logic [1:0]  warp_sub;
    logic [3:0]  warp_blk;
    logic        fin_valid;
    logic [5:0]  fin_id;
    logic        drain_valid;
    logic [5:0]  drain_id;
    logic        done_valid;
    logic [3:0]  done_id;
    logic        done_ack;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    block_dispatch i_block_dispatch (.*);

    // threads, regs/thread, smem, warps, first id, first sub, block-id
    localparam int NROW = 6;
    localparam int TBL [NROW][7] = '{
        '{100,  16, 2,  4,  0, 0, 0},
        '{33,   16, 2,  2,  4, 0, 1},
        '{1,     8, 1,  1,  6, 2, 2},
        '{64,    8, 1,  2,  7, 3, 3},
        '{32,    8, 1,  1,  9, 1, 4},
        '{1024,  8, 4, 32, 10, 2, 5}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_threads = '0; req_regs = '0; req_smem = '0;
        fin_valid = 1'b0; fin_id = '0; drain_valid = 1'b0; drain_id = '0; done_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_req(input int t, input int r, input int s);
        req_threads = 11'(t); req_regs = 8'(r); req_smem = 7'(s);
        #1;
    endtask

    // Admit a block and let its warps drain out of the issue stage.
    task automatic admit(input int t, input int r, input int s, input int nw);
        set_req(t, r, s);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (nw) @(negedge clk);
    endtask

    task automatic pulse_fin(input int id);
        fin_valid = 1'b1; fin_id = 6'(id);
        @(negedge clk);
        fin_valid = 1'b0;
    endtask

    task automatic pulse_drain(input int id);
        drain_valid = 1'b1; drain_id = 6'(id);
        @(negedge clk);
        drain_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        done_ack = 1'b1;
        @(negedge clk);
        done_ack = 1'b0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        set_req(32, 8, 1);
        chk("R9 ready after reset", int'(req_ready), 1);
        chk("R9 warp_valid after reset", int'(warp_valid), 0);
        chk("R9 done_valid after reset", int'(done_valid), 0);

        // R1 R3 R4: table of requests
        for (int r = 0; r < NROW; r++) begin
            set_req(TBL[r][0], TBL[r][1], TBL[r][2]);
            req_valid = 1'b1;
            chk("R2 ready for fitting block", int'(req_ready), 1);
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < TBL[r][3]; k++) begin
                chk("R1 warp issued", int'(warp_valid), 1);
                chk("R3 warp id", int'(warp_id), TBL[r][4] + k);
                chk("R4 sub-partition", int'(warp_sub), (TBL[r][5] + k) % 4);
                chk("R3 block id", int'(warp_blk), TBL[r][6]);
                @(negedge clk);
            end
            chk("R1 no extra warp", int'(warp_valid), 0);
        end

        // R2: 22 warp slots and 53 smem units remain
        set_req(736, 1, 1);
        chk("R2 warp pool short", int'(req_ready), 0);
        set_req(704, 1, 1);
        chk("R2 warp pool exact", int'(req_ready), 1);
        set_req(32, 1, 54);
        chk("R2 smem short", int'(req_ready), 0);
        set_req(32, 1, 53);
        chk("R2 smem exact", int'(req_ready), 1);

        // R5: block 2 holds warp 6
        pulse_drain(6);
        chk("R5 drain before finish ignored", int'(done_valid), 0);
        pulse_fin(6);
        chk("R5 finish alone does not release", int'(done_valid), 0);
        pulse_drain(6);
        chk("R7 block done after last release", int'(done_valid), 1);
        chk("R7 done id", int'(done_id), 2);
        pulse_fin(60);
        pulse_drain(60);
        chk("R5 idle slot ignored", int'(done_id), 2);

        // R7: blocks 4 and 1 also complete; lowest id first
        pulse_fin(9);  pulse_drain(9);
        pulse_fin(4);  pulse_drain(4);
        chk("R7 one warp left keeps block 1 live", int'(done_id), 2);
        pulse_fin(5);  pulse_drain(5);
        chk("R7 lowest pending first", int'(done_id), 1);
        pulse_ack();
        chk("R7 next after ack", int'(done_id), 2);
        pulse_ack();
        chk("R7 last pending", int'(done_id), 4);
        pulse_ack();
        chk("R7 none pending", int'(done_valid), 0);

        // R8: shared memory returns only on ack
        do_reset();
        admit(32, 1, 64, 1);
        set_req(32, 1, 1);
        chk("R8 smem full", int'(req_ready), 0);
        pulse_fin(0); pulse_drain(0);
        chk("R8 done raised", int'(done_valid), 1);
        set_req(32, 1, 1);
        chk("R8 smem still held before ack", int'(req_ready), 0);
        pulse_ack();
        set_req(32, 1, 1);
        chk("R8 smem back after ack", int'(req_ready), 1);

        // R6: registers return per warp
        do_reset();
        admit(1024, 64, 1, 32);
        set_req(32, 1, 1);
        chk("R2 register pool short", int'(req_ready), 0);
        pulse_fin(0); pulse_drain(0);
        chk("R6 block not yet done", int'(done_valid), 0);
        set_req(32, 64, 1);
        chk("R6 one warp of registers back", int'(req_ready), 1);
        set_req(64, 64, 1);
        chk("R6 only one warp returned", int'(req_ready), 0);

        // R10: 8 blocks of 256 threads fill the multiprocessor
        do_reset();
        for (int b = 0; b < 8; b++) begin
            set_req(256, 8, 1);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R10 resident block id", int'(warp_blk), b);
            chk("R10 first warp id", int'(warp_id), 8 * b);
            repeat (8) @(negedge clk);
        end
        set_req(32, 8, 1);
        chk("R10 ninth block refused", int'(req_ready), 0);

        // R2: block slots run out before warp slots
        do_reset();
        for (int b = 0; b < 16; b++) admit(32, 1, 1, 1);
        set_req(32, 1, 1);
        chk("R2 block slots exhausted", int'(req_ready), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule